// File: doc/BRIEF.md
# SPI Flash User-Command Sequencer

The block runs one programmable serial-flash transaction each time software asks for one. Before starting, software programs a set of configuration registers over a simple register bus. It enables any mix of three phases: an opcode phase, an address phase and a data phase. It also writes each phase's bit count minus one and the serial clock's low and high phase counts. Outgoing data is preloaded into a 16-word buffer. Writing the start bit launches the sequence. The same bit reads back as 1 while the transaction runs, so software polls it to wait for completion. After that, received data is read from the buffer. Chip select is driven outside the block.

The sequencer is a five-state machine.
- ST_IDLE waits for the start request and goes to ST_PICK at the opcode phase.
- ST_PICK checks the current phase. A disabled phase is skipped and the machine moves to the next phase in the same state. An enabled phase loads the bit counter and goes to ST_LOW. Past the data phase the machine goes to ST_FINISH.
- ST_LOW holds SCK low for the low count. On expiry it samples MISO and goes to ST_HIGH.
- ST_HIGH holds SCK high for the high count. On expiry it either advances to the next bit in ST_LOW, or leaves the phase for ST_PICK after the phase's last bit.
- ST_FINISH returns to ST_IDLE and clears busy.

A software reset forces ST_IDLE from any state. The data phase runs as data-out when both data enables are set.

Top module: `spi_cmd_seq`

## Requirements
- R1: Writing a 1 to bit 18 of offset 0x00 while idle starts a transaction. Bit 18 of offset 0x00 then reads 1 from the cycle after the write until the transaction ends, and reads 0 afterwards.
- R2: Phases run in the fixed order opcode, address, data. In offset 0x1C, bit 31 enables the opcode phase, bit 30 the address phase, bit 28 data-in and bit 27 data-out. A disabled phase contributes no SCK pulse.
- R3: The opcode phase sends (bits 31:28 of offset 0x24) + 1 bits, MSB first, from the 16-bit value formed by zeros above the opcode byte held in bits 7:0 of offset 0x24.
- R4: With bit 1 of offset 0x1C set, the address phase sends all 32 bits of offset 0x04 from bit 31 down. With bit 1 clear, it sends 24 bits, bits 31 down to 8. The field in bits 31:26 of offset 0x20 is stored and read back.
- R5: The data-out phase sends (bits 25:17 of offset 0x20) + 1 bits. Stream bit k is taken from buffer word k/32 (offset 0x40 + 4*word), byte lane (k/8) mod 4 occupying bits 8*lane+7 down to 8*lane, MSB of each byte first.
- R6: The data-in phase captures (bits 16:8 of offset 0x20) + 1 MISO bits into the same buffer positions as R5. Buffer bits past the last captured bit keep their previous values, and MOSI is 0 during data-in.
- R7: SCK idles low. Within a phase it stays low for (bits 5:0 of offset 0x18) + 1 clock cycles and high for (bits 11:6) + 1 cycles. MOSI changes only while SCK is low, and MISO is taken just before each rising edge.
- R8: A transaction with every phase disabled produces no SCK pulse and clears busy within 8 cycles of the start write.
- R9: While busy, writes to offsets 0x04, 0x18, 0x1C, 0x20, 0x24 and the buffer have no effect on stored values or on the transaction in progress.
- R10: Writing a 1 to bit 31 of offset 0x30 aborts any transaction. Busy reads 0 and SCK is low from the next cycle, no further SCK pulse follows, configuration registers keep their values, and offset 0x30 reads 0.
- R11: After reset all configuration registers and buffer words read 0, busy is 0, and SCK and MOSI are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access select |
| reg_we | input | 1 | Write strobe (1 = write, 0 = read) |
| reg_addr | input | 7 | Byte offset of the accessed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| sck | output | 1 | Serial clock to the flash |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
A wrong phase or bit counter shows at the pins within one SCK period, as a shifted or missing bit in the MOSI stream or a pulse count off by one per bit. The bench therefore captures every MOSI bit at each SCK rise and compares the whole stream. A bad buffer index or byte-lane mapping stays hidden until the buffer is read back after completion, so every data-in transaction is followed by a full buffer readback. A busy flag that clears early or late appears as a wrong number of SCK pulses by the time polling ends. A missed write guard appears in the readback of the configuration registers after the transaction.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    localparam int WORD_W = 32;

    localparam logic [6:0] OFS_CMD   = 7'h00;
    localparam logic [6:0] OFS_ADDR  = 7'h04;
    localparam logic [6:0] OFS_CLK   = 7'h18;
    localparam logic [6:0] OFS_PHASE = 7'h1C;
    localparam logic [6:0] OFS_LEN   = 7'h20;
    localparam logic [6:0] OFS_OP    = 7'h24;
    localparam logic [6:0] OFS_SRST  = 7'h30;

    localparam int START_BIT = 18;
    localparam int SRST_BIT  = 31;
    localparam int EN_OP_BIT = 31;
    localparam int EN_AD_BIT = 30;
    localparam int EN_DI_BIT = 28;
    localparam int EN_DO_BIT = 27;
    localparam int WIDE_BIT  = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PICK,
        ST_LOW,
        ST_HIGH,
        ST_FINISH
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_OP,
        PH_ADDR,
        PH_DATA,
        PH_END
    } phase_t;

    typedef struct packed {
        logic        op_en;
        logic        addr_en;
        logic        din_en;
        logic        dout_en;
        logic        addr_wide;
        logic [3:0]  op_last;
        logic [7:0]  op_val;
        logic [31:0] addr;
        logic [8:0]  dout_last;
        logic [8:0]  din_last;
        logic [5:0]  lo_last;
        logic [5:0]  hi_last;
    } seq_cfg_t;

endpackage

// File: rtl/spi_seq_regs.sv
module spi_seq_regs
    import spi_seq_pkg::*;
#(
    parameter int BUF_WORDS = 16,
    parameter int BIDX_W    = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [6:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              busy,
    input  logic [BIDX_W-1:0] bit_idx,
    input  logic              bit_we,
    input  logic              bit_val,
    output logic              buf_bit,
    output logic              start_req,
    output logic              srst_req,
    output seq_cfg_t          cfg
);

    localparam int WIDX_W = BIDX_W - 5;

    logic [31:0]       r_addr;
    logic [31:0]       r_clk;
    logic [31:0]       r_phase;
    logic [31:0]       r_len;
    logic [31:0]       r_op;
    logic [WORD_W-1:0] buf_mem [BUF_WORDS];

    logic              wr_any;
    logic              cfg_ok;
    logic              buf_hit;
    logic [WIDX_W-1:0] host_w;
    logic [WIDX_W-1:0] core_w;
    logic [4:0]        core_pos;

    assign wr_any   = reg_en & reg_we;
    assign cfg_ok   = wr_any & ~busy;
    assign buf_hit  = reg_addr[6] & (reg_addr[1:0] == 2'b00);
    assign host_w   = reg_addr[WIDX_W+1:2];
    assign core_w   = bit_idx[BIDX_W-1:5];
    assign core_pos = {bit_idx[4:3], ~bit_idx[2:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_addr  <= '0;
            r_clk   <= '0;
            r_phase <= '0;
            r_len   <= '0;
            r_op    <= '0;
        end else if (cfg_ok) begin
            case (reg_addr)
                OFS_ADDR:  r_addr  <= reg_wdata;
                OFS_CLK:   r_clk   <= reg_wdata;
                OFS_PHASE: r_phase <= reg_wdata;
                OFS_LEN:   r_len   <= reg_wdata;
                OFS_OP:    r_op    <= reg_wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BUF_WORDS; i++) begin
                buf_mem[i] <= '0;
            end
        end else if (cfg_ok && buf_hit) begin
            buf_mem[host_w] <= reg_wdata;
        end else if (bit_we) begin
            buf_mem[core_w][core_pos] <= bit_val;
        end
    end

    assign buf_bit   = buf_mem[core_w][core_pos];
    assign start_req = cfg_ok & (reg_addr == OFS_CMD) & reg_wdata[START_BIT];
    assign srst_req  = wr_any & (reg_addr == OFS_SRST) & reg_wdata[SRST_BIT];

    assign cfg.op_en     = r_phase[EN_OP_BIT];
    assign cfg.addr_en   = r_phase[EN_AD_BIT];
    assign cfg.din_en    = r_phase[EN_DI_BIT];
    assign cfg.dout_en   = r_phase[EN_DO_BIT];
    assign cfg.addr_wide = r_phase[WIDE_BIT];
    assign cfg.op_last   = r_op[31:28];
    assign cfg.op_val    = r_op[7:0];
    assign cfg.addr      = r_addr;
    assign cfg.dout_last = r_len[25:17];
    assign cfg.din_last  = r_len[16:8];
    assign cfg.lo_last   = r_clk[5:0];
    assign cfg.hi_last   = r_clk[11:6];

    always_comb begin
        reg_rdata = '0;
        if (buf_hit) begin
            reg_rdata = buf_mem[host_w];
        end else begin
            case (reg_addr)
                OFS_CMD:   reg_rdata[START_BIT] = busy;
                OFS_ADDR:  reg_rdata = r_addr;
                OFS_CLK:   reg_rdata = r_clk;
                OFS_PHASE: reg_rdata = r_phase;
                OFS_LEN:   reg_rdata = r_len;
                OFS_OP:    reg_rdata = r_op;
                default:   reg_rdata = '0;
            endcase
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_any) |=> $stable({r_addr, r_clk, r_phase, r_len, r_op})); // R9

endmodule

// File: rtl/spi_seq_timer.sv
module spi_seq_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = (cnt == '0);

endmodule

// File: rtl/spi_seq_fsm.sv
module spi_seq_fsm
    import spi_seq_pkg::*;
#(
    parameter int BIDX_W = 9,
    parameter int TMR_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_cfg_t          cfg,
    input  logic              start,
    input  logic              srst,
    input  logic              miso,
    input  logic              buf_bit,
    input  logic              tmr_expire,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    output logic              tmr_load,
    output logic [TMR_W-1:0]  tmr_val,
    output logic [BIDX_W-1:0] bit_idx,
    output logic              bit_we,
    output logic              bit_val
);

    seq_state_t        state, state_n;
    phase_t            ph, ph_n;
    logic [BIDX_W-1:0] cnt, cnt_n;
    logic [BIDX_W-1:0] cur_last;
    logic              ph_on;
    logic              at_last;
    logic [15:0]       op_vec;
    logic [3:0]        op_sel;
    logic [4:0]        ad_sel;

    always_comb begin
        cur_last = '0;
        ph_on    = 1'b0;
        unique case (ph)
            PH_OP: begin
                cur_last = BIDX_W'(cfg.op_last);
                ph_on    = cfg.op_en;
            end
            PH_ADDR: begin
                cur_last = cfg.addr_wide ? BIDX_W'(31) : BIDX_W'(23);
                ph_on    = cfg.addr_en;
            end
            PH_DATA: begin
                cur_last = cfg.dout_en ? BIDX_W'(cfg.dout_last) : BIDX_W'(cfg.din_last);
                ph_on    = cfg.dout_en | cfg.din_en;
            end
            PH_END: begin
                cur_last = '0;
                ph_on    = 1'b0;
            end
        endcase
    end

    assign at_last = (cnt == cur_last);

    always_comb begin
        state_n = state;
        ph_n    = ph;
        cnt_n   = cnt;
        if (srst) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state_n = ST_PICK;
                        ph_n    = PH_OP;
                    end
                end
                ST_PICK: begin
                    if (ph == PH_END) begin
                        state_n = ST_FINISH;
                    end else if (ph_on) begin
                        state_n = ST_LOW;
                        cnt_n   = '0;
                    end else begin
                        ph_n = phase_t'(ph + 2'd1);
                    end
                end
                ST_LOW: begin
                    if (tmr_expire) begin
                        state_n = ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (tmr_expire) begin
                        if (at_last) begin
                            state_n = ST_PICK;
                            ph_n    = phase_t'(ph + 2'd1);
                        end else begin
                            state_n = ST_LOW;
                            cnt_n   = cnt + 1'b1;
                        end
                    end
                end
                ST_FINISH: begin
                    state_n = ST_IDLE;
                end
                default: begin
                    state_n = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ph    <= PH_OP;
            cnt   <= '0;
        end else begin
            state <= state_n;
            ph    <= ph_n;
            cnt   <= cnt_n;
        end
    end

    assign op_vec = {8'h00, cfg.op_val};
    assign op_sel = cfg.op_last - cnt[3:0];
    assign ad_sel = 5'd31 - cnt[4:0];

    always_comb begin
        busy     = (state != ST_IDLE);
        sck      = (state == ST_HIGH);
        tmr_load = ((state == ST_PICK) && (ph != PH_END) && ph_on)
                 || ((state == ST_LOW) && tmr_expire)
                 || ((state == ST_HIGH) && tmr_expire && !at_last);
        tmr_val  = (state == ST_LOW) ? cfg.hi_last : cfg.lo_last;
        bit_idx  = cnt;
        bit_val  = miso;
        bit_we   = (state == ST_LOW) && tmr_expire && (ph == PH_DATA)
                 && cfg.din_en && !cfg.dout_en && !srst;
        mosi     = 1'b0;
        if ((state == ST_LOW) || (state == ST_HIGH)) begin
            unique case (ph)
                PH_OP:   mosi = op_vec[op_sel];
                PH_ADDR: mosi = cfg.addr[ad_sel];
                PH_DATA: mosi = cfg.dout_en & buf_bit;
                PH_END:  mosi = 1'b0;
            endcase
        end
    end

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy); // R1
    AST_SRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!busy && !sck)); // R10
    AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi)); // R7
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_LOW) || (state == ST_HIGH)) |-> (cnt <= cur_last)); // R5

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_seq_pkg::*;
#(
    parameter int BUF_WORDS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_en,
    input  logic        reg_we,
    input  logic [6:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        sck,
    output logic        mosi,
    input  logic        miso
);

    localparam int BIDX_W = $clog2(BUF_WORDS * WORD_W);
    localparam int TMR_W  = 6;

    seq_cfg_t          cfg;
    logic              busy;
    logic              start_req;
    logic              srst_req;
    logic              buf_bit;
    logic              bit_we;
    logic              bit_val;
    logic [BIDX_W-1:0] bit_idx;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_expire;

    spi_seq_regs #(
        .BUF_WORDS (BUF_WORDS),
        .BIDX_W    (BIDX_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_en    (reg_en),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .bit_idx   (bit_idx),
        .bit_we    (bit_we),
        .bit_val   (bit_val),
        .buf_bit   (buf_bit),
        .start_req (start_req),
        .srst_req  (srst_req),
        .cfg       (cfg)
    );

    spi_seq_timer #(
        .CNT_W (TMR_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_expire)
    );

    spi_seq_fsm #(
        .BIDX_W (BIDX_W),
        .TMR_W  (TMR_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg),
        .start      (start_req),
        .srst       (srst_req),
        .miso       (miso),
        .buf_bit    (buf_bit),
        .tmr_expire (tmr_expire),
        .busy       (busy),
        .sck        (sck),
        .mosi       (mosi),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .bit_idx    (bit_idx),
        .bit_we     (bit_we),
        .bit_val    (bit_val)
    );

endmodule

// File: tb/sim_spi_cmd_seq.sv
module sim_spi_cmd_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sck;
    logic        mosi;
    logic        miso;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [1023:0] in_pat = '0;
    int  rise_cnt = 0;
    int  fall_cnt = 0;
    bit  cap [0:1023];
    time t_r0, t_f0, t_r1;

    logic [31:0] bmem [16];
    bit  exp_s [0:1023];
    int  exp_n, pre_n, cur_dbits;
    bit  cur_di, cur_do;
    logic [31:0] cur_clk;

    always #2 clk = ~clk;

    spi_cmd_seq u0 (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sck(sck), .mosi(mosi), .miso(miso)
    );

    assign miso = in_pat[rise_cnt & 1023];

    always @(posedge sck) begin
        if (rise_cnt < 1024) cap[rise_cnt] = mosi;
        if (rise_cnt == 0) t_r0 = $time;
        if (rise_cnt == 1) t_r1 = $time;
        rise_cnt = rise_cnt + 1;
    end

    always @(negedge sck) begin
        if (fall_cnt == 0) t_f0 = $time;
        fall_cnt = fall_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        reg_en = 1'b0;
    endtask

    function automatic bit model_bit(input int k);
        return bmem[k / 32][((k % 32) / 8) * 8 + 7 - (k % 8)];
    endfunction

    task automatic preload();
        for (int w = 0; w < 16; w++) begin
            bmem[w] = $urandom;
            wr(7'h40 + 7'(4 * w), bmem[w]);
        end
        for (int i = 0; i < 32; i++) in_pat[i*32 +: 32] = $urandom;
    endtask

    task automatic setup_txn(input bit e_op, input bit e_ad, input bit wide, input bit e_di,
                             input bit e_do, input int op_bits, input logic [7:0] opv,
                             input logic [31:0] adr, input int d_bits, input int lo, input int hi);
        int nb;
        cur_clk = (32'(5) << 12) | (32'(hi) << 6) | 32'(lo);
        wr(7'h04, adr);
        wr(7'h18, cur_clk);
        wr(7'h1C, (32'(e_op) << 31) | (32'(e_ad) << 30) | (32'(e_di) << 28) |
                  (32'(e_do) << 27) | (32'(wide) << 1));
        wr(7'h20, ((wide ? 32'd31 : 32'd23) << 26) | (32'(d_bits - 1) << 17) |
                  (32'(d_bits - 1) << 8));
        wr(7'h24, (32'(op_bits - 1) << 28) | 32'(opv));
        exp_n = 0;
        if (e_op) begin
            for (int i = op_bits - 1; i >= 0; i--) begin
                exp_s[exp_n] = (i < 8) ? opv[i] : 1'b0;
                exp_n++;
            end
        end
        if (e_ad) begin
            nb = wide ? 32 : 24;
            for (int i = 31; i >= 32 - nb; i--) begin
                exp_s[exp_n] = adr[i];
                exp_n++;
            end
        end
        pre_n = exp_n;
        cur_di = e_di & !e_do;
        cur_do = e_do;
        cur_dbits = (e_di | e_do) ? d_bits : 0;
        for (int k = 0; k < cur_dbits; k++) begin
            exp_s[exp_n] = e_do ? model_bit(k) : 1'b0;
            exp_n++;
        end
    endtask

    task automatic start_txn();
        rise_cnt = 0;
        fall_cnt = 0;
        wr(7'h00, 32'h0004_0000);
    endtask

    task automatic wait_done(output int cyc, output bit first_busy);
        logic [31:0] v;
        rd(7'h00, v);
        first_busy = v[18];
        cyc = 1;
        while (v[18] && cyc < 30000) begin
            rd(7'h00, v);
            cyc++;
        end
    endtask

    task automatic check_txn(input string tag);
        int mism;
        logic [31:0] v;
        mism = 0;
        chk(rise_cnt == exp_n, {tag, " R2 SCK pulse count"}, rise_cnt, exp_n);
        for (int i = 0; i < exp_n && i < 1024; i++) begin
            if (cap[i] != exp_s[i]) mism++;
        end
        chk(mism == 0, {tag, " R3 R4 R5 MOSI stream mismatches"}, mism, 0);
        chk(sck == 1'b0, {tag, " R7 SCK idle low"}, sck, 0);
        if (cur_di) begin
            for (int k = 0; k < cur_dbits; k++) begin
                bmem[k / 32][((k % 32) / 8) * 8 + 7 - (k % 8)] = in_pat[pre_n + k];
            end
            mism = 0;
            for (int w = 0; w < 16; w++) begin
                rd(7'h40 + 7'(4 * w), v);
                if (v != bmem[w]) mism++;
            end
            chk(mism == 0, {tag, " R6 buffer words after data-in"}, mism, 0);
        end
    endtask

    task automatic run_txn(input string tag, input bit e_op, input bit e_ad, input bit wide,
                           input bit e_di, input bit e_do, input int op_bits,
                           input logic [7:0] opv, input logic [31:0] adr, input int d_bits,
                           input int lo, input int hi);
        int cyc;
        bit fb;
        setup_txn(e_op, e_ad, wide, e_di, e_do, op_bits, opv, adr, d_bits, lo, hi);
        start_txn();
        wait_done(cyc, fb);
        chk(fb == 1'b1, {tag, " R1 busy after start"}, fb, 1);
        check_txn(tag);
    endtask

    initial begin
        #(4 * 190000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, keep;
        int cyc, r;
        bit fb;
        void'($urandom(32'd20240611));
        for (int w = 0; w < 16; w++) bmem[w] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        chk(sck == 1'b0 && mosi == 1'b0, "R11 pins after reset", {sck, mosi}, 0);
        rd(7'h00, v); chk(v == 0, "R11 command reg", v, 0);
        rd(7'h04, v); chk(v == 0, "R11 address reg", v, 0);
        rd(7'h18, v); chk(v == 0, "R11 clock reg", v, 0);
        rd(7'h1C, v); chk(v == 0, "R11 phase reg", v, 0);
        rd(7'h20, v); chk(v == 0, "R11 length reg", v, 0);
        rd(7'h24, v); chk(v == 0, "R11 opcode reg", v, 0);
        rd(7'h7C, v); chk(v == 0, "R11 last buffer word", v, 0);

        // R7 timing with an 8-bit opcode only
        run_txn("opcode", 1, 0, 0, 0, 0, 8, 8'h9F, 32'h0, 1, 1, 2);
        chk(t_f0 - t_r0 == 12, "R7 high phase width ns", t_f0 - t_r0, 12);
        chk(t_r1 - t_f0 == 8, "R7 low phase width ns", t_r1 - t_f0, 8);

        // R3 opcode longer than a byte sends zeros first
        run_txn("wide opcode", 1, 0, 0, 0, 0, 10, 8'hFF, 32'h0, 1, 0, 0);

        // R6 identification-style read
        preload();
        run_txn("id read", 1, 0, 0, 1, 0, 8, 8'h9F, 32'h0, 24, 0, 1);

        // R4 24-bit address, full-buffer data-in
        preload();
        run_txn("read 24b", 1, 1, 0, 1, 0, 8, 8'h03, 32'hA5C3_1E00, 512, 0, 0);
        rd(7'h20, v);
        chk(v[31:26] == 6'd23, "R4 address length field readback", v[31:26], 23);

        // R4 R5 32-bit address, single data-out bit
        preload();
        run_txn("write 32b 1bit", 1, 1, 1, 0, 1, 8, 8'h12, 32'h8123_4567, 1, 1, 0);

        // R5 data-out without opcode or address
        preload();
        run_txn("data only", 0, 0, 0, 0, 1, 8, 8'h00, 32'h0, 77, 2, 1);

        // R8 all phases disabled
        setup_txn(0, 0, 0, 0, 0, 8, 8'h00, 32'h0, 1, 0, 0);
        start_txn();
        wait_done(cyc, fb);
        chk(cyc <= 8, "R8 cycles until idle", cyc, 8);
        chk(rise_cnt == 0, "R8 no SCK pulse", rise_cnt, 0);

        // R9 writes while busy are ignored
        preload();
        setup_txn(1, 0, 0, 0, 1, 8, 8'h02, 32'h0, 64, 2, 2);
        keep = cur_clk;
        start_txn();
        wr(7'h18, 32'h0000_003F);
        wr(7'h40, ~bmem[0]);
        wr(7'h24, 32'h0);
        wait_done(cyc, fb);
        check_txn("busy write");
        rd(7'h18, v); chk(v == keep, "R9 clock reg kept", v, keep);
        rd(7'h40, v); chk(v == bmem[0], "R9 buffer word kept", v, bmem[0]);
        rd(7'h24, v); chk(v == 32'h7000_0002, "R9 opcode reg kept", v, 32'h7000_0002);

        // R10 software reset mid-transaction
        preload();
        setup_txn(1, 1, 1, 0, 1, 8, 8'h02, 32'h0, 512, 3, 3);
        keep = cur_clk;
        start_txn();
        repeat (50) @(negedge clk);
        wr(7'h30, 32'h8000_0000);
        rd(7'h00, v); chk(v[18] == 1'b0, "R10 busy cleared", v[18], 0);
        chk(sck == 1'b0, "R10 SCK low", sck, 0);
        r = rise_cnt;
        repeat (40) @(negedge clk);
        chk(rise_cnt == r, "R10 no further SCK pulse", rise_cnt, r);
        rd(7'h30, v); chk(v == 0, "R10 reset reg reads zero", v, 0);
        rd(7'h18, v); chk(v == keep, "R10 config kept", v, keep);
        run_txn("after reset", 1, 0, 0, 0, 0, 8, 8'h05, 32'h0, 1, 0, 0);

        // random transactions
        for (int t = 0; t < 12; t++) begin
            int mode;
            preload();
            mode = $urandom_range(0, 2);
            run_txn("random", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    1'($urandom_range(0, 1)), mode == 1, mode == 2,
                    $urandom_range(1, 12), 8'($urandom), $urandom,
                    $urandom_range(1, 512), $urandom_range(0, 3), $urandom_range(0, 3));
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule